// File: doc/BRIEF.md
# Per-source trigger interrupt controller

This block collects up to 32 interrupt sources and turns them into two request lines and one wake line. Every source has its own three-bit trigger code that selects rising-edge, falling-edge or dual-edge capture, active-high or active-low level sensing, or no sensing at all. Each source also has:

- a mask bit,
- a wake-enable bit,
- a source-enable bit,
- a steering bit that chooses which request line it drives.

Software reaches every setting over a single-cycle register bus. Each control register has three word addresses: one where written ones set bits, one where written ones clear bits, and one that reads the current value. The word address splits into a group in bits [5:2] and an operation in bits [1:0], where 0 means set, 1 means clear and 2 means read. The groups are:

| Group | Register |
|---|---|
| 0 | trigger bit 0 |
| 1 | trigger bit 1 |
| 2 | trigger bit 2 |
| 3 | mask |
| 4 | wake enable |
| 5 | steering |
| 6 | source enable |
| 7 | rising capture (op 1 clears, op 2 reads) |
| 8 | falling capture (op 1 clears, op 2 reads) |
| 9 | request-0 pending (op 2 reads), request-1 pending (op 3 reads) |
| 10 | scratch test word (op 0 writes the whole word, op 2 reads it) |

Reads are combinational on the address. Writes take effect at the clock edge on which `bus_wr` is high. The inputs are asynchronous. Each input passes through two synchronizing flops, and an edge is found by comparing the synchronized sample with the one before it. An interrupt handler reads a pending word, services the sources it shows, and clears the edge captures it has handled.

Top module: `trig_intc`

## Requirements
- R1: After reset, all trigger bits, mask, wake enable, source enable, both capture registers and the test word read 0. Steering reads all ones. `req0_o`, `req1_o` and `wake_o` are 0.
- R2: For each control group 0..6, writing ones at op 0 sets those bits and writing ones at op 1 clears them. Zero bits in the written data leave state unchanged, and op 2 returns the value.
- R3: The trigger code of source i is {bit2[i],bit1[i],bit0[i]}: 000 off, 001 rising, 010 falling, 011 both edges, 101 high level, 110 low level. A rising-only source never sets its falling capture, and a falling-only source never sets its rising capture.
- R4: An enabled source with an edge code captures a matching edge of its synchronized input into the rising or falling capture register. A dual-edge source can set both registers.
- R5: Writing ones at a capture register's op 1 clears those captures. A capture that arrives in the same cycle as its clear wins, and the bit stays set.
- R6: Level sources are not captured. They are active exactly while the synchronized input matches the code's polarity.
- R7: A source with its steering bit set feeds request 0. A source with its steering bit clear feeds request 1, never both.
- R8: A source reaches a pending word only while its mask bit is set. A capture taken while masked is held and appears once the mask is set.
- R9: Pending word 0 (address 38) and pending word 1 (address 39) show the active, masked-in sources steered to request 0 and request 1.
- R10: `req0_o` and `req1_o` are the registered OR of the matching pending word. They follow it one cycle later.
- R11: `wake_o` is the registered OR of the active sources whose wake-enable bit is set, whatever their mask.
- R12: A source with its source-enable bit clear captures no edges and is never active.
- R13: Codes 100 and 111 behave as off: the source is never active and never captures.
- R14: The test word at address 40 stores the whole written word and reads it back at address 42. It has no effect on pending words or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Raw asynchronous interrupt inputs |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 6 | Word address: group in [5:2], operation in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake line |

## Verification
Edge capture and the software clear of the same capture bit can land on one clock edge. The bench provokes this by raising an input and then asserting the clear write exactly two edges later, which lines it up with the capture edge. It then judges that the bit reads back as still set. Around that directed case, random trigger codes, masks, steering and input toggles are scored against a bench model of captures, pending words and line outputs.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;
  localparam int GRP_W   = 4;
  localparam int OP_W    = 2;
  localparam int ADDR_W  = GRP_W + OP_W;
  localparam int DATA_W  = 32;
  localparam int N_CTL   = 7;

  // register groups, address bits [5:2]
  localparam logic [GRP_W-1:0] GRP_CFG0   = 4'd0;
  localparam logic [GRP_W-1:0] GRP_CFG1   = 4'd1;
  localparam logic [GRP_W-1:0] GRP_CFG2   = 4'd2;
  localparam logic [GRP_W-1:0] GRP_MASK   = 4'd3;
  localparam logic [GRP_W-1:0] GRP_WAKE   = 4'd4;
  localparam logic [GRP_W-1:0] GRP_STEER  = 4'd5;
  localparam logic [GRP_W-1:0] GRP_SRCEN  = 4'd6;
  localparam logic [GRP_W-1:0] GRP_RISE   = 4'd7;
  localparam logic [GRP_W-1:0] GRP_FALL   = 4'd8;
  localparam logic [GRP_W-1:0] GRP_PEND   = 4'd9;
  localparam logic [GRP_W-1:0] GRP_TEST   = 4'd10;

  // operations, address bits [1:0]
  localparam logic [OP_W-1:0] OP_SET = 2'd0;
  localparam logic [OP_W-1:0] OP_CLR = 2'd1;
  localparam logic [OP_W-1:0] OP_RD  = 2'd2;
  localparam logic [OP_W-1:0] OP_RD2 = 2'd3;

  // trigger codes {bit2,bit1,bit0}
  localparam logic [2:0] TRG_OFF  = 3'b000;
  localparam logic [2:0] TRG_RISE = 3'b001;
  localparam logic [2:0] TRG_FALL = 3'b010;
  localparam logic [2:0] TRG_BOTH = 3'b011;
  localparam logic [2:0] TRG_HIGH = 3'b101;
  localparam logic [2:0] TRG_LOW  = 3'b110;

  function automatic logic [ADDR_W-1:0] reg_addr(logic [GRP_W-1:0] g, logic [OP_W-1:0] op);
    return {g, op};
  endfunction
endpackage

// File: rtl/trig_intc_ctlreg.sv
module trig_intc_ctlreg #(
  parameter int W        = 32,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] RST_VAL = RST_ONES ? '1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/trig_intc_src.sv
module trig_intc_src
  import trig_intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_i,
  input  logic [2:0] code_i,
  input  logic       en_i,
  input  logic       rclr_i,
  input  logic       fclr_i,
  output logic       rise_o,
  output logic       fall_o,
  output logic       act_o
);
  logic s1_q, s2_q, prev_q;
  logic rise_ev, fall_ev, rise_arm, fall_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_ev  = s2_q & ~prev_q;
  assign fall_ev  = ~s2_q & prev_q;
  assign rise_arm = en_i && (code_i == TRG_RISE || code_i == TRG_BOTH);
  assign fall_arm = en_i && (code_i == TRG_FALL || code_i == TRG_BOTH);

  // a new capture outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= (rise_o & ~rclr_i) | (rise_ev & rise_arm);
      fall_o <= (fall_o & ~fclr_i) | (fall_ev & fall_arm);
    end
  end

  always_comb begin
    case (code_i)
      TRG_RISE, TRG_FALL, TRG_BOTH: act_o = en_i & (rise_o | fall_o);
      TRG_HIGH:                     act_o = en_i & s2_q;
      TRG_LOW:                      act_o = en_i & ~s2_q;
      default:                      act_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_intc.sv
module trig_intc
  import trig_intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  logic [GRP_W-1:0] grp;
  logic [OP_W-1:0]  op;
  logic [NSRC-1:0]  wd;
  logic [NSRC-1:0]  ctl_q [N_CTL];
  logic [NSRC-1:0]  mask_q, wake_q, steer_q, en_q;
  logic [NSRC-1:0]  rise_q, fall_q, act, rclr, fclr;
  logic [NSRC-1:0]  pend0, pend1;
  logic [DATA_W-1:0] test_q;

  assign grp = bus_addr[ADDR_W-1:OP_W];
  assign op  = bus_addr[OP_W-1:0];
  assign wd  = bus_wdata[NSRC-1:0];

  for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
    logic [NSRC-1:0] set_v, clr_v;
    assign set_v = (bus_wr && grp == GRP_W'(g) && op == OP_SET) ? wd : '0;
    assign clr_v = (bus_wr && grp == GRP_W'(g) && op == OP_CLR) ? wd : '0;
    trig_intc_ctlreg #(
      .W        (NSRC),
      .RST_ONES (g == int'(GRP_STEER))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v),
      .clr_i (clr_v),
      .q_o   (ctl_q[g])
    );
  end

  assign mask_q  = ctl_q[GRP_MASK];
  assign wake_q  = ctl_q[GRP_WAKE];
  assign steer_q = ctl_q[GRP_STEER];
  assign en_q    = ctl_q[GRP_SRCEN];
  assign rclr    = (bus_wr && grp == GRP_RISE && op == OP_CLR) ? wd : '0;
  assign fclr    = (bus_wr && grp == GRP_FALL && op == OP_CLR) ? wd : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    trig_intc_src u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (src_in[i]),
      .code_i ({ctl_q[GRP_CFG2][i], ctl_q[GRP_CFG1][i], ctl_q[GRP_CFG0][i]}),
      .en_i   (en_q[i]),
      .rclr_i (rclr[i]),
      .fclr_i (fclr[i]),
      .rise_o (rise_q[i]),
      .fall_o (fall_q[i]),
      .act_o  (act[i])
    );
  end

  assign pend0 = act & mask_q & steer_q;
  assign pend1 = act & mask_q & ~steer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req0_o <= 1'b0;
      req1_o <= 1'b0;
      wake_o <= 1'b0;
      test_q <= '0;
    end else begin
      req0_o <= |pend0;
      req1_o <= |pend1;
      wake_o <= |(act & wake_q);
      if (bus_wr && grp == GRP_TEST && op == OP_SET) test_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < N_CTL; g++)
      if (grp == GRP_W'(g) && op == OP_RD) bus_rdata = DATA_W'(ctl_q[g]);
    if (grp == GRP_RISE && op == OP_RD)  bus_rdata = DATA_W'(rise_q);
    if (grp == GRP_FALL && op == OP_RD)  bus_rdata = DATA_W'(fall_q);
    if (grp == GRP_PEND && op == OP_RD)  bus_rdata = DATA_W'(pend0);
    if (grp == GRP_PEND && op == OP_RD2) bus_rdata = DATA_W'(pend1);
    if (grp == GRP_TEST && op == OP_RD)  bus_rdata = test_q;
  end
endmodule

// File: rtl/trig_intc_chk.sv
module trig_intc_chk
  import trig_intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              req0_o,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   rise_q,
  input logic [NSRC-1:0]   pend0,
  input logic [NSRC-1:0]   pend1
);
  localparam logic [ADDR_W-1:0] A_MSET = {GRP_MASK, OP_SET};
  localparam logic [ADDR_W-1:0] A_MCLR = {GRP_MASK, OP_CLR};
  localparam logic [ADDR_W-1:0] A_RCLR = {GRP_RISE, OP_CLR};

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSET) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MCLR) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R2
  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0); // R7
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 | pend1) & ~mask_q) == '0); // R8
  AST_REQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req0_o) |-> ($past(pend0) != '0)); // R10
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_RCLR) |=> (($past(rise_q) & ~rise_q) == '0)); // R5
endmodule

bind trig_intc trig_intc_chk #(.NSRC(NSRC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .req0_o    (req0_o),
  .mask_q    (mask_q),
  .rise_q    (rise_q),
  .pend0     (pend0),
  .pend1     (pend1)
);

// File: tb/trig_intc_tb_top.sv
module trig_intc_tb_top;
  import trig_intc_pkg::*;
  localparam int CLK_P = 10;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [N-1:0] src_in = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic req0_o, req1_o, wake_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [N-1:0] m_ctl [N_CTL];
  logic [N-1:0] m_rise, m_fall, m_in;
  logic [31:0]  m_test;

  always #(CLK_P/2) clk = ~clk;

  trig_intc #(.NSRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [GRP_W-1:0] g, logic [OP_W-1:0] op, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {g, op}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (int'(g) < N_CTL) begin
      if (op == OP_SET) m_ctl[g] = m_ctl[g] | d;
      if (op == OP_CLR) m_ctl[g] = m_ctl[g] & ~d;
    end
    if (g == GRP_RISE && op == OP_CLR) m_rise = m_rise & ~d;
    if (g == GRP_FALL && op == OP_CLR) m_fall = m_fall & ~d;
    if (g == GRP_TEST && op == OP_SET) m_test = d;
  endtask

  task automatic rd(logic [GRP_W-1:0] g, logic [OP_W-1:0] op, output logic [31:0] d);
    @(negedge clk);
    bus_addr = {g, op};
    #1 d = bus_rdata;
  endtask

  function automatic logic [2:0] code(int i);
    return {m_ctl[GRP_CFG2][i], m_ctl[GRP_CFG1][i], m_ctl[GRP_CFG0][i]};
  endfunction

  function automatic logic [N-1:0] model_act();
    logic [N-1:0] a = '0;
    for (int i = 0; i < N; i++) begin
      case (code(i))
        TRG_RISE, TRG_FALL, TRG_BOTH: a[i] = m_rise[i] | m_fall[i];
        TRG_HIGH: a[i] = m_in[i];
        TRG_LOW:  a[i] = ~m_in[i];
        default:  a[i] = 1'b0;
      endcase
    end
    return a & m_ctl[GRP_SRCEN];
  endfunction

  // apply new inputs, fold the edges into the model, let the pipeline settle
  task automatic drive(logic [N-1:0] v);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (m_ctl[GRP_SRCEN][i]) begin
        if (!m_in[i] && v[i] && (code(i) == TRG_RISE || code(i) == TRG_BOTH)) m_rise[i] = 1'b1;
        if (m_in[i] && !v[i] && (code(i) == TRG_FALL || code(i) == TRG_BOTH)) m_fall[i] = 1'b1;
      end
    end
    m_in = v;
    src_in = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    logic [N-1:0] a, p0, p1;
    a  = model_act();
    p0 = a & m_ctl[GRP_MASK] & m_ctl[GRP_STEER];
    p1 = a & m_ctl[GRP_MASK] & ~m_ctl[GRP_STEER];
    for (int g = 0; g < N_CTL; g++) begin
      rd(GRP_W'(g), OP_RD, d); chk({tag, " R2 ctl"}, d, m_ctl[g]);
    end
    rd(GRP_RISE, OP_RD, d);  chk({tag, " R4 rise"}, d, m_rise);
    rd(GRP_FALL, OP_RD, d);  chk({tag, " R4 fall"}, d, m_fall);
    rd(GRP_PEND, OP_RD, d);  chk({tag, " R9 pend0"}, d, p0);
    rd(GRP_PEND, OP_RD2, d); chk({tag, " R9 pend1"}, d, p1);
    chk({tag, " R10 req0"}, {31'd0, req0_o}, {31'd0, |p0});
    chk({tag, " R10 req1"}, {31'd0, req1_o}, {31'd0, |p1});
    chk({tag, " R11 wake"}, {31'd0, wake_o}, {31'd0, |(a & m_ctl[GRP_WAKE])});
  endtask

  task automatic set_code(int i, logic [2:0] c);
    wr(GRP_CFG0, c[0] ? OP_SET : OP_CLR, 32'(1) << i);
    wr(GRP_CFG1, c[1] ? OP_SET : OP_CLR, 32'(1) << i);
    wr(GRP_CFG2, c[2] ? OP_SET : OP_CLR, 32'(1) << i);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'h1A2B3C);
    for (int g = 0; g < N_CTL; g++) m_ctl[g] = '0;
    m_ctl[GRP_STEER] = '1;
    m_rise = '0; m_fall = '0; m_in = '0; m_test = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(GRP_STEER, OP_RD, d); chk("R1 steer", d, 32'hFFFF_FFFF);
    rd(GRP_TEST, OP_RD, d);  chk("R1 test", d, 32'h0);
    check_all("R1");

    // R2 set/clear leave zero bits alone
    wr(GRP_MASK, OP_SET, 32'h0000_F0F0);
    wr(GRP_MASK, OP_CLR, 32'h0000_0030);
    rd(GRP_MASK, OP_RD, d); chk("R2 mask", d, 32'h0000_F0C0);
    wr(GRP_MASK, OP_CLR, 32'hFFFF_FFFF);

    // R3/R4 rising-only source 0, dual-edge source 1, steered to req0
    wr(GRP_SRCEN, OP_SET, 32'h0000_00FF);
    wr(GRP_MASK, OP_SET, 32'h0000_0007);
    set_code(0, TRG_RISE);
    set_code(1, TRG_BOTH);
    drive(32'h3);
    check_all("R4 up");
    drive(32'h0);
    rd(GRP_FALL, OP_RD, d); chk("R3 rise-only no fall", d & 32'h1, 32'h0);
    chk("R4 both edges", d & 32'h2, 32'h2);
    check_all("R4 down");

    // R5 clear, then capture and clear on the same edge
    wr(GRP_RISE, OP_CLR, 32'h3);
    wr(GRP_FALL, OP_CLR, 32'h3);
    check_all("R5 clear");
    @(negedge clk); src_in[0] = 1'b1; m_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = {GRP_RISE, OP_CLR}; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 1'b0;
    m_rise[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(GRP_RISE, OP_RD, d); chk("R5 capture wins", d & 32'h1, 32'h1);
    check_all("R5");

    // R7 steer source 0 to req1
    wr(GRP_STEER, OP_CLR, 32'h1);
    repeat (2) @(negedge clk);
    check_all("R7");

    // R6 level high on source 2, low on source 3
    set_code(2, TRG_HIGH);
    set_code(3, TRG_LOW);
    wr(GRP_MASK, OP_SET, 32'h8);
    drive(32'h5);
    check_all("R6 high");
    drive(32'h1);
    rd(GRP_RISE, OP_RD, d); chk("R6 no latch", d & 32'hC, 32'h0);
    check_all("R6 low");

    // R13 unused codes behave as off
    set_code(4, 3'b100);
    set_code(5, 3'b111);
    wr(GRP_MASK, OP_SET, 32'h30);
    drive(32'h31);
    rd(GRP_PEND, OP_RD, d); chk("R13 pend0", d & 32'h30, 32'h0);
    drive(32'h01);
    rd(GRP_FALL, OP_RD, d); chk("R13 no capture", d & 32'h30, 32'h0);
    check_all("R13");

    // R8 masked capture is kept
    set_code(6, TRG_RISE);
    drive(32'h41);
    rd(GRP_RISE, OP_RD, d); chk("R8 held", d & 32'h40, 32'h40);
    rd(GRP_PEND, OP_RD, d); chk("R8 hidden", d & 32'h40, 32'h0);
    wr(GRP_WAKE, OP_SET, 32'h40);
    repeat (2) @(negedge clk);
    chk("R11 wake unmasked", {31'd0, wake_o}, 32'h1);
    wr(GRP_MASK, OP_SET, 32'h40);
    repeat (2) @(negedge clk);
    check_all("R8");

    // R12 disabled source neither captures nor drives
    set_code(8, TRG_RISE);
    wr(GRP_MASK, OP_SET, 32'h100);
    drive(32'h141);
    rd(GRP_RISE, OP_RD, d); chk("R12 no capture", d & 32'h100, 32'h0);
    check_all("R12");

    // R14 test word
    wr(GRP_TEST, OP_SET, 32'hA5C3_0F96);
    rd(GRP_TEST, OP_RD, d); chk("R14 readback", d, 32'hA5C3_0F96);
    check_all("R14");

    // random sweep
    for (int it = 0; it < 300; it++) begin
      for (int k = 0; k < 2; k++)
        wr(GRP_W'($urandom_range(0, N_CTL - 1)), $urandom_range(0, 1) ? OP_SET : OP_CLR, $urandom);
      if ($urandom_range(0, 3) == 0) wr(GRP_RISE, OP_CLR, $urandom);
      if ($urandom_range(0, 3) == 0) wr(GRP_FALL, OP_CLR, $urandom);
      repeat (2) @(negedge clk);
      drive(m_in ^ $urandom);
      check_all("RND");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule